// File: doc/BRIEF.md
# Interrupt Acknowledge and End-of-Interrupt Unit

This unit is the per-processor side of an interrupt controller. A distributor supplies it with vectors: which interrupts are enabled, which are pending, how each one is triggered, and what priority each one has. It also supplies a pending matrix for the software interrupts, kept separately for each sending processor. Every cycle the unit picks one eligible candidate and holds it as the highest pending interrupt. While a candidate is held, it drives an interrupt request line to the processor.

Software reads the acknowledge register to claim the held interrupt. That read has side effects. The interrupt becomes active. Its pending bit is cleared through a pulse if it is edge-triggered or a software interrupt. The request line drops until arbitration runs again. A read when nothing is eligible, or when an enable is off, returns the spurious ID 1023. Writing an interrupt ID to the completion register retires that interrupt. A completion for an interrupt that is not active is reported on an error pulse and changes nothing.

Software interrupts (IDs below `NUM_SGI`) are pending and active per source processor. The acknowledge word carries the source number beside the ID, and a completion must name the same source.

Top module: `cpuif_ack_eoi`

## Requirements
- R1: After reset `irq_o` is low, nothing is active, and the control and mask registers read as zero.
- R2: An acknowledge read returns 1023 and causes no pulse and no state change unless `dist_en_i` is 1, control bit 0 is 1, and an eligible candidate is held.
- R3: A candidate is eligible when it is enabled, pending and not active, and its priority is strictly below the mask. The winner has the lowest priority value. Ties go to the lowest ID, and within a software interrupt to the lowest source.
- R4: A successful acknowledge sets the interrupt active and emits `set_act_o` for one cycle, with `evt_id_o`/`evt_src_o`, in the cycle after the read. `rdata_o` is valid in that same cycle.
- R5: `clr_pend_o` pulses with the acknowledge when `irq_edge_i` of the ID is 1 (edge-triggered) or the ID is a software interrupt. It stays low for a level-sensitive ID (edge bit 0).
- R6: In the cycle after an acknowledge, `irq_o` is low. It returns one cycle later if another candidate is eligible.
- R7: The acknowledge word is bits 9:0 for the ID and bits 12:10 for the source, with zero upper bits. The source is 0 for non-software IDs. The pending bit of software interrupt `i` from source `s` is `sgi_pend_i[i*NUM_CPU+s]`, and its active bit is `sgi_act_o` at the same index.
- R8: A completion write (address 3; bits 9:0 ID, bits 12:10 source) clears the active state of that ID/source.
- R9: A completion naming an ID/source that is not active, or an ID outside the implemented range, pulses `eoi_err_o` in the next cycle and leaves all active state unchanged.
- R10: Address 0 (control, 32 bits, bit 0 is the interface enable) and address 1 (priority mask, `PRIO_W` bits) read back exactly what was written. A write to address 2 is ignored, and a read of address 3 returns 0.
- R11: After a completion, a still-eligible interrupt raises `irq_o` again two cycles after the write and can be acknowledged again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dist_en_i | input | 1 | Distributor global enable |
| irq_en_i | input | NUM_IRQ | Per-ID enable |
| irq_pend_i | input | NUM_IRQ | Per-ID pending (bits below NUM_SGI unused) |
| irq_edge_i | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| irq_prio_i | input | NUM_IRQ*PRIO_W | Priority of ID i at bits i*PRIO_W upward |
| sgi_pend_i | input | NUM_SGI*NUM_CPU | Software interrupt pending per source |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write |
| addr_i | input | 2 | 0 control, 1 mask, 2 acknowledge, 3 completion |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request to the processor |
| set_act_o | output | 1 | Pulse: the acknowledged ID became active |
| clr_pend_o | output | 1 | Pulse: distributor should clear pending |
| evt_id_o | output | 10 | ID of the acknowledge event |
| evt_src_o | output | 3 | Source of the acknowledge event |
| act_o | output | NUM_IRQ | Active state per ID (software IDs: OR of sources) |
| sgi_act_o | output | NUM_SGI*NUM_CPU | Software interrupt active per source |
| eoi_err_o | output | 1 | Pulse: completion for a non-active interrupt |

## Verification
The bench builds the unit with 32 IDs, 16 of them software interrupts, eight sources and 8-bit priorities. With these values the highest ID (31) can be acknowledged, the source field uses all three bits, and a software interrupt from source 5 encodes to 5123. Priority ties between IDs 25 and 30 and equal-to-mask priorities probe the strict ordering. A level-sensitive ID is acknowledged twice around a completion, which shows the pending-keep and re-arbitration paths together.

// File: rtl/cpuif_pkg.sv
`timescale 1ns/1ps
package cpuif_pkg;
  localparam int ID_W  = 10;
  localparam int SRC_W = 3;
  localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_MASK = 2'd1,
    A_ACK  = 2'd2,
    A_EOI  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cpuif_arb.sv
`timescale 1ns/1ps
module cpuif_arb
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_SGI = 16,
  parameter int NUM_CPU = 8,
  parameter int PRIO_W  = 8
) (
  input  logic                       gate_i,
  input  logic [NUM_IRQ-1:0]         en_i,
  input  logic [NUM_IRQ-1:0]         pend_i,
  input  logic [NUM_IRQ-1:0]         act_i,
  input  logic [NUM_IRQ*PRIO_W-1:0]  prio_i,
  input  logic [NUM_SGI*NUM_CPU-1:0] sgi_pend_i,
  input  logic [NUM_SGI*NUM_CPU-1:0] sgi_act_i,
  input  logic [PRIO_W-1:0]          mask_i,
  output logic                       win_vld_o,
  output logic [ID_W-1:0]            win_id_o,
  output logic [SRC_W-1:0]           win_src_o,
  output logic [PRIO_W-1:0]          win_prio_o
);
  localparam int NSGI_SLOTS = NUM_SGI * NUM_CPU;

  logic [NSGI_SLOTS-1:0] sgi_elig;
  logic [NUM_IRQ-1:0]    spi_elig;

  for (genvar g = 0; g < NSGI_SLOTS; g++) begin : g_sgi_elig
    localparam int ID = g / NUM_CPU;
    assign sgi_elig[g] = gate_i & en_i[ID] & sgi_pend_i[g] & ~sgi_act_i[g] &
                         (prio_i[ID*PRIO_W +: PRIO_W] < mask_i);
  end

  for (genvar j = 0; j < NUM_IRQ; j++) begin : g_spi_elig
    if (j < NUM_SGI) begin : g_none
      assign spi_elig[j] = 1'b0;
    end else begin : g_chk
      assign spi_elig[j] = gate_i & en_i[j] & pend_i[j] & ~act_i[j] &
                           (prio_i[j*PRIO_W +: PRIO_W] < mask_i);
    end
  end

  // ascending scan, strict compare: lowest index wins ties
  always_comb begin
    win_vld_o  = 1'b0;
    win_id_o   = SPUR_ID;
    win_src_o  = '0;
    win_prio_o = '1;
    for (int g = 0; g < NSGI_SLOTS; g++) begin
      if (sgi_elig[g] && (!win_vld_o || prio_i[(g/NUM_CPU)*PRIO_W +: PRIO_W] < win_prio_o)) begin
        win_vld_o  = 1'b1;
        win_id_o   = ID_W'(g / NUM_CPU);
        win_src_o  = SRC_W'(g % NUM_CPU);
        win_prio_o = prio_i[(g/NUM_CPU)*PRIO_W +: PRIO_W];
      end
    end
    for (int j = NUM_SGI; j < NUM_IRQ; j++) begin
      if (spi_elig[j] && (!win_vld_o || prio_i[j*PRIO_W +: PRIO_W] < win_prio_o)) begin
        win_vld_o  = 1'b1;
        win_id_o   = ID_W'(j);
        win_src_o  = '0;
        win_prio_o = prio_i[j*PRIO_W +: PRIO_W];
      end
    end
  end

  logic unused_lo;
  assign unused_lo = ^{pend_i[NUM_SGI-1:0], act_i[NUM_SGI-1:0]};
endmodule

// File: rtl/cpuif_active.sv
`timescale 1ns/1ps
module cpuif_active
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_SGI = 16,
  parameter int NUM_CPU = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ack_i,
  input  logic [ID_W-1:0]            ack_id_i,
  input  logic [SRC_W-1:0]           ack_src_i,
  input  logic                       eoi_i,
  input  logic [ID_W-1:0]            eoi_id_i,
  input  logic [SRC_W-1:0]           eoi_src_i,
  output logic [NUM_IRQ-1:0]         act_o,
  output logic [NUM_SGI*NUM_CPU-1:0] sgi_act_o,
  output logic                       eoi_err_o
);
  localparam int NSGI_SLOTS = NUM_SGI * NUM_CPU;

  logic [NSGI_SLOTS-1:0] sgi_q, sgi_ack_sel, sgi_eoi_sel;
  logic [NUM_IRQ-1:0]    spi_q, spi_ack_sel, spi_eoi_sel;
  logic                  eoi_hit, err_q;

  for (genvar g = 0; g < NSGI_SLOTS; g++) begin : g_sgi_sel
    assign sgi_ack_sel[g] = (ack_id_i == ID_W'(g / NUM_CPU)) && (ack_src_i == SRC_W'(g % NUM_CPU));
    assign sgi_eoi_sel[g] = (eoi_id_i == ID_W'(g / NUM_CPU)) && (eoi_src_i == SRC_W'(g % NUM_CPU));
  end

  for (genvar j = 0; j < NUM_IRQ; j++) begin : g_spi_sel
    if (j < NUM_SGI) begin : g_sgi_id
      assign spi_ack_sel[j] = 1'b0;
      assign spi_eoi_sel[j] = 1'b0;
      assign act_o[j]       = |sgi_q[j*NUM_CPU +: NUM_CPU];
    end else begin : g_spi_id
      assign spi_ack_sel[j] = (ack_id_i == ID_W'(j));
      assign spi_eoi_sel[j] = (eoi_id_i == ID_W'(j));
      assign act_o[j]       = spi_q[j];
    end
  end

  assign eoi_hit = |(sgi_eoi_sel & sgi_q) | |(spi_eoi_sel & spi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sgi_q <= '0;
      spi_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (ack_i) begin
        sgi_q <= sgi_q | sgi_ack_sel;
        spi_q <= spi_q | spi_ack_sel;
      end else if (eoi_i && eoi_hit) begin
        sgi_q <= sgi_q & ~sgi_eoi_sel;
        spi_q <= spi_q & ~spi_eoi_sel;
      end
      err_q <= eoi_i && !eoi_hit;
    end
  end

  assign sgi_act_o = sgi_q;
  assign eoi_err_o = err_q;

  a_r4_ack_adds_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> $countones({sgi_q, spi_q}) == $past($countones({sgi_q, spi_q})) + 1);

  a_r8_eoi_removes_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && eoi_hit && !ack_i) |=> $countones({sgi_q, spi_q}) == $past($countones({sgi_q, spi_q})) - 1);

  a_r9_bad_eoi_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !eoi_hit && !ack_i) |=> ({sgi_q, spi_q} == $past({sgi_q, spi_q})) && eoi_err_o);
endmodule

// File: rtl/cpuif_ack_eoi.sv
`timescale 1ns/1ps
module cpuif_ack_eoi
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_SGI = 16,
  parameter int NUM_CPU = 8,
  parameter int PRIO_W  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       dist_en_i,
  input  logic [NUM_IRQ-1:0]         irq_en_i,
  input  logic [NUM_IRQ-1:0]         irq_pend_i,
  input  logic [NUM_IRQ-1:0]         irq_edge_i,
  input  logic [NUM_IRQ*PRIO_W-1:0]  irq_prio_i,
  input  logic [NUM_SGI*NUM_CPU-1:0] sgi_pend_i,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [1:0]                 addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  output logic                       rvalid_o,
  output logic                       irq_o,
  output logic                       set_act_o,
  output logic                       clr_pend_o,
  output logic [ID_W-1:0]            evt_id_o,
  output logic [SRC_W-1:0]           evt_src_o,
  output logic [NUM_IRQ-1:0]         act_o,
  output logic [NUM_SGI*NUM_CPU-1:0] sgi_act_o,
  output logic                       eoi_err_o
);
  logic [31:0]       ctrl_q;
  logic [PRIO_W-1:0] mask_q;
  logic              hpi_vld_q;
  logic [ID_W-1:0]   hpi_id_q;
  logic [SRC_W-1:0]  hpi_src_q;
  logic [31:0]       rdata_q;
  logic              rvalid_q, set_act_q, clr_pend_q;
  logic [ID_W-1:0]   evt_id_q;
  logic [SRC_W-1:0]  evt_src_q;

  logic              gate, rd, wr, ack_fire, eoi_fire, hpi_edge, hpi_is_sgi;
  logic              win_vld;
  logic [ID_W-1:0]   win_id;
  logic [SRC_W-1:0]  win_src;
  logic [PRIO_W-1:0] win_prio;
  reg_addr_e         addr;

  assign addr     = reg_addr_e'(addr_i);
  assign gate     = dist_en_i & ctrl_q[0];
  assign rd       = req_i & ~we_i;
  assign wr       = req_i & we_i;
  assign ack_fire = rd && (addr == A_ACK) && gate && hpi_vld_q;
  assign eoi_fire = wr && (addr == A_EOI);

  assign hpi_is_sgi = (hpi_id_q < ID_W'(NUM_SGI));
  always_comb begin
    hpi_edge = 1'b0;
    for (int j = 0; j < NUM_IRQ; j++)
      if (hpi_id_q == ID_W'(j)) hpi_edge = irq_edge_i[j];
  end

  cpuif_arb #(
    .NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)
  ) u_arb (
    .gate_i     (gate),
    .en_i       (irq_en_i),
    .pend_i     (irq_pend_i),
    .act_i      (act_o),
    .prio_i     (irq_prio_i),
    .sgi_pend_i (sgi_pend_i),
    .sgi_act_i  (sgi_act_o),
    .mask_i     (mask_q),
    .win_vld_o  (win_vld),
    .win_id_o   (win_id),
    .win_src_o  (win_src),
    .win_prio_o (win_prio)
  );

  cpuif_active #(
    .NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI), .NUM_CPU(NUM_CPU)
  ) u_active (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ack_i     (ack_fire),
    .ack_id_i  (hpi_id_q),
    .ack_src_i (hpi_src_q),
    .eoi_i     (eoi_fire),
    .eoi_id_i  (wdata_i[ID_W-1:0]),
    .eoi_src_i (wdata_i[ID_W +: SRC_W]),
    .act_o     (act_o),
    .sgi_act_o (sgi_act_o),
    .eoi_err_o (eoi_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      mask_q     <= '0;
      hpi_vld_q  <= 1'b0;
      hpi_id_q   <= SPUR_ID;
      hpi_src_q  <= '0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
      set_act_q  <= 1'b0;
      clr_pend_q <= 1'b0;
      evt_id_q   <= SPUR_ID;
      evt_src_q  <= '0;
    end else begin
      if (ack_fire) begin
        hpi_vld_q <= 1'b0;
        hpi_id_q  <= SPUR_ID;
        hpi_src_q <= '0;
        evt_id_q  <= hpi_id_q;
        evt_src_q <= hpi_src_q;
      end else begin
        hpi_vld_q <= win_vld;
        hpi_id_q  <= win_id;
        hpi_src_q <= win_src;
      end
      set_act_q  <= ack_fire;
      clr_pend_q <= ack_fire && (hpi_is_sgi || hpi_edge);

      if (wr && addr == A_CTRL) ctrl_q <= wdata_i;
      if (wr && addr == A_MASK) mask_q <= wdata_i[PRIO_W-1:0];

      rvalid_q <= rd;
      if (rd) begin
        unique case (addr)
          A_CTRL:  rdata_q <= ctrl_q;
          A_MASK:  rdata_q <= 32'(mask_q);
          A_ACK:   rdata_q <= ack_fire ? 32'({hpi_src_q, hpi_id_q}) : 32'(SPUR_ID);
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o    = rdata_q;
  assign rvalid_o   = rvalid_q;
  assign irq_o      = hpi_vld_q;
  assign set_act_o  = set_act_q;
  assign clr_pend_o = clr_pend_q;
  assign evt_id_o   = evt_id_q;
  assign evt_src_o  = evt_src_q;

  a_r6_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |=> !irq_o && set_act_o);

  a_r2_gated_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr == A_ACK && !gate) |=> (rdata_o[ID_W-1:0] == SPUR_ID) && !set_act_o);

  a_r5_clr_only_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_pend_o |-> set_act_o);

  a_r3_winner_below_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld |-> (win_prio < mask_q) && gate);

  a_r7_spi_src_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_act_o && evt_id_o >= ID_W'(NUM_SGI)) |-> evt_src_o == '0);
endmodule

// File: tb/cpuif_ack_eoi_tb_top.sv
`timescale 1ns/1ps
module cpuif_ack_eoi_tb_top;
  localparam int NUM_IRQ = 32;
  localparam int NUM_SGI = 16;
  localparam int NUM_CPU = 8;
  localparam int PRIO_W  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dist_en = 1'b0;
  logic [NUM_IRQ-1:0] en = '0, pend = '0, edge_cfg = '0;
  logic [NUM_IRQ*PRIO_W-1:0] prio = '0;
  logic [NUM_SGI*NUM_CPU-1:0] sgi_pend = '0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, irq, set_act, clr_pend, eoi_err;
  logic [9:0] evt_id;
  logic [2:0] evt_src;
  logic [NUM_IRQ-1:0] act;
  logic [NUM_SGI*NUM_CPU-1:0] sgi_act;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cpuif_ack_eoi #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI), .NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .dist_en_i(dist_en), .irq_en_i(en), .irq_pend_i(pend),
    .irq_edge_i(edge_cfg), .irq_prio_i(prio), .sgi_pend_i(sgi_pend), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq),
    .set_act_o(set_act), .clr_pend_o(clr_pend), .evt_id_o(evt_id), .evt_src_o(evt_src),
    .act_o(act), .sgi_act_o(sgi_act), .eoi_err_o(eoi_err));

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, a, e);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // read: result and event pulses sampled at the negedge after the capturing edge
  task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic sa, output logic cp);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata; sa = set_act; cp = clr_pend;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output logic err);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    err = eoi_err;
  endtask

  task automatic set_prio(input int id, input logic [7:0] p);
    prio[id*PRIO_W +: PRIO_W] = p;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic sa, cp;
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 active after reset", act, 0);
    rd(2'd0, d, sa, cp); chk("R1 ctrl reset", d, 0);
    rd(2'd1, d, sa, cp); chk("R1 mask reset", d, 0);
    rd(2'd2, d, sa, cp); chk("R2 ack at reset spurious", d, 32'h3FF);
  endtask

  task automatic t_regs;
    logic [31:0] d; logic sa, cp, e;
    wr(2'd0, 32'hA5A5_0000, e); rd(2'd0, d, sa, cp); chk("R10 ctrl readback", d, 32'hA5A5_0000);
    wr(2'd1, 32'h0000_01F0, e); rd(2'd1, d, sa, cp); chk("R10 mask readback", d, 32'hF0);
    wr(2'd2, 32'h0000_0005, e); rd(2'd1, d, sa, cp); chk("R10 ack write ignored", d, 32'hF0);
    rd(2'd3, d, sa, cp); chk("R10 eoi reads zero", d, 0);
  endtask

  task automatic t_gating;
    logic [31:0] d; logic sa, cp, e;
    en[20] = 1; pend[20] = 1; edge_cfg[20] = 1; set_prio(20, 8'h40);
    dist_en = 1;
    cyc(2);
    chk("R2 irq off while cpu disabled", 32'(irq), 0);
    rd(2'd2, d, sa, cp);
    chk("R2 ack spurious cpu disabled", d, 32'h3FF); chk("R2 no set pulse", 32'(sa), 0);
    wr(2'd0, 32'h1, e); dist_en = 0; cyc(2);
    rd(2'd2, d, sa, cp);
    chk("R2 ack spurious dist disabled", d, 32'h3FF); chk("R2 no set pulse dist off", 32'(sa), 0);
    chk("R2 nothing active", act, 0);
    dist_en = 1; cyc(2);
    chk("R3 irq once enabled", 32'(irq), 1);
  endtask

  task automatic t_edge_ack;
    logic [31:0] d; logic sa, cp, e;
    rd(2'd2, d, sa, cp);
    chk("R4 ack id 20", d, 32'd20);
    chk("R4 set_act pulse", 32'(sa), 1); chk("R5 edge clears pending", 32'(cp), 1);
    chk("R7 evt id", 32'(evt_id), 20); chk("R7 evt src zero", 32'(evt_src), 0);
    chk("R6 irq low after ack", 32'(irq), 0);
    chk("R4 active set", 32'(act[20]), 1);
    pend[20] = 0;
    wr(2'd3, 32'd20, e);
    chk("R8 eoi no error", 32'(e), 0); chk("R8 active cleared", 32'(act[20]), 0);
    en[20] = 0;
  endtask

  task automatic t_level;
    logic [31:0] d; logic sa, cp, e;
    en[21] = 1; pend[21] = 1; edge_cfg[21] = 0; set_prio(21, 8'h10);
    cyc(2);
    rd(2'd2, d, sa, cp);
    chk("R4 ack level id", d, 32'd21); chk("R5 level keeps pending", 32'(cp), 0);
    cyc(2);
    chk("R3 active level not rearbitrated", 32'(irq), 0);
    wr(2'd3, 32'd21, e);
    chk("R8 eoi level ok", 32'(e), 0); chk("R11 irq not yet", 32'(irq), 0);
    cyc(1);
    chk("R11 irq back after eoi", 32'(irq), 1);
    rd(2'd2, d, sa, cp); chk("R11 reacknowledge", d, 32'd21);
    pend[21] = 0; en[21] = 0;
    wr(2'd3, 32'd21, e);
  endtask

  task automatic t_prio;
    logic [31:0] d; logic sa, cp, e;
    en[17] = 1; en[25] = 1; en[30] = 1;
    pend[17] = 1; pend[25] = 1; pend[30] = 1;
    edge_cfg[17] = 1; edge_cfg[25] = 1; edge_cfg[30] = 1;
    set_prio(17, 8'h80); set_prio(25, 8'h40); set_prio(30, 8'h40);
    cyc(2);
    rd(2'd2, d, sa, cp); chk("R3 lowest prio then lowest id", d, 32'd25); pend[25] = 0;
    cyc(1); chk("R6 irq returns after one cycle", 32'(irq), 1);
    rd(2'd2, d, sa, cp); chk("R3 tie partner next", d, 32'd30); pend[30] = 0;
    cyc(1);
    rd(2'd2, d, sa, cp); chk("R3 highest value last", d, 32'd17); pend[17] = 0;
    wr(2'd3, 32'd25, e); chk("R8 eoi 25", 32'(e), 0);
    wr(2'd3, 32'd30, e); chk("R8 eoi 30", 32'(e), 0);
    wr(2'd3, 32'd17, e); chk("R8 eoi 17", 32'(e), 0);
    chk("R8 all inactive", act, 0);
    en = '0;
  endtask

  task automatic t_mask;
    logic [31:0] d; logic sa, cp, e;
    en[31] = 1; pend[31] = 1; edge_cfg[31] = 1; set_prio(31, 8'h60);
    wr(2'd1, 32'h60, e); cyc(2);
    chk("R3 equal to mask blocked", 32'(irq), 0);
    rd(2'd2, d, sa, cp); chk("R3 equal to mask spurious", d, 32'h3FF);
    wr(2'd1, 32'h61, e); cyc(2);
    rd(2'd2, d, sa, cp); chk("R3 below mask top id", d, 32'd31);
    pend[31] = 0; en[31] = 0;
    wr(2'd3, 32'd31, e);
    wr(2'd1, 32'hF0, e);
  endtask

  task automatic t_sgi;
    logic [31:0] d; logic sa, cp, e;
    en[3] = 1; set_prio(3, 8'h20);
    sgi_pend[3*8+5] = 1; sgi_pend[3*8+2] = 1;
    cyc(2);
    rd(2'd2, d, sa, cp);
    chk("R7 sgi lowest source first", d, 32'h0000_0803);
    chk("R5 sgi clears pending", 32'(cp), 1); chk("R7 evt src", 32'(evt_src), 2);
    sgi_pend[3*8+2] = 0;
    cyc(1);
    rd(2'd2, d, sa, cp); chk("R7 sgi source 5", d, 32'd5123);
    sgi_pend[3*8+5] = 0;
    chk("R7 per-source active", 32'(sgi_act[31:24]), 32'h24);
    wr(2'd3, 32'h0000_0803, e);
    chk("R8 sgi eoi ok", 32'(e), 0); chk("R8 only source 2 cleared", 32'(sgi_act[31:24]), 32'h20);
    wr(2'd3, 32'h0000_0803, e);
    chk("R9 repeated eoi flagged", 32'(e), 1); chk("R9 state kept", 32'(sgi_act[31:24]), 32'h20);
    wr(2'd3, 32'h0000_0C03, e);
    chk("R9 wrong source flagged", 32'(e), 1);
    wr(2'd3, 32'd1023, e); chk("R9 out of range flagged", 32'(e), 1);
    wr(2'd3, 32'd22, e); chk("R9 inactive spi flagged", 32'(e), 1);
    chk("R9 no state change", 32'(sgi_act[31:24]), 32'h20);
    wr(2'd3, 32'd5123, e);
    chk("R8 source 5 cleared", 32'(e), 0); chk("R8 sgi all clear", sgi_act, 0);
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_regs();
    t_gating();
    t_edge_ack();
    t_level();
    t_prio();
    t_mask();
    t_sgi();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule